// File: doc/BRIEF.md
# LCD Common Scan and Segment Address Sequencer

This block runs the refresh side of a dot-matrix LCD controller. Once per line period, marked by a one-cycle `line_tick` enable, it moves the active common (row) to the next line of the frame. It shows that line both as a binary index and as a one-hot select vector. A frame holds as many lines as the programmed duty asks for. The scan can run upward from the first common or downward toward it. A pulse marks the first line of each new frame.

Alongside the scan, the block supplies the display RAM column address that each segment driver position must read. It does the same for the small row of static icon positions. A mirror flag reverses both mappings, so the panel module can be routed with the segment pins in either order.

Direction and duty are sampled only at frame boundaries, so a frame in progress is never torn. The mirror flag is applied on the next clock.

Top module: `lcdscan_seq`

## Requirements
- R1: A synchronous active-high reset sets the scan position to the first line of a frame. It samples `duty_lines` and `com_rev` at that clock. After the reset clock, `com_idx` is 0 when `com_rev`=0 and N-1 when `com_rev`=1, and `frame_start` is 0.
- R2: With the latched direction 0, each clock with `line_tick`=1 raises `com_idx` by one, from 0 up to N-1. The tick after N-1 returns it to 0.
- R3: With the latched direction 1, each tick lowers `com_idx` by one, from N-1 down to 0. The tick after 0 returns it to N-1.
- R4: The frame length N equals `duty_lines` when that value is 1 to MAX_COM (128). A value of 0, or one above MAX_COM, selects N = MAX_COM.
- R5: Changes to `duty_lines` or `com_rev` only take effect on the tick that ends a frame. They are not used by ticks inside a frame.
- R6: `frame_start` is 1 for exactly the one cycle after a tick that begins a new frame, and 0 otherwise. In that cycle `com_idx` is the new frame's first line.
- R7: `com_sel` always has exactly one bit set, namely bit `com_idx`. Bit i drives common line i+1.
- R8: On clocks with `line_tick`=0, `com_idx` and `com_sel` keep their values.
- R9: Segment slot k occupies bits [k*7 +: 7] of `seg_addr`. One clock after `seg_mirror` is sampled, slot k holds column k when the flag is 0 and column 127-k when it is 1.
- R10: Icon slot k occupies bits [k*3 +: 3] of `icon_addr` (5 slots). It holds k when `seg_mirror` is 0 and 4-k when it is 1, with the same one-clock latency.
- R11: A change of `seg_mirror` reaches the address outputs on the next clock, whether or not `line_tick` is high and regardless of frame position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle enable per line period |
| duty_lines | input | 8 | Lines per frame (0 or >128 means 128) |
| com_rev | input | 1 | Scan direction: 0 ascending, 1 descending |
| seg_mirror | input | 1 | Mirror column-to-segment mapping |
| com_idx | output | 7 | Active common index (0 = first common line) |
| com_sel | output | 128 | One-hot common select |
| frame_start | output | 1 | Pulse on the first line of a frame |
| seg_addr | output | 896 | Column address per segment slot, 7 bits each |
| icon_addr | output | 15 | Icon column address per icon slot, 3 bits each |

## Verification
The assertions assume the design was reset once before use. They also assume `line_tick` is a clean per-cycle enable, so that one tick moves the scan by exactly one line. Any value of `duty_lines` is accepted, because out-of-range settings are folded to the full 128 lines.

The stimulus draws duty values mostly from short frames, so that many frame boundaries occur in the run. It also draws the out-of-range and single-line settings at random. Direction, duty and mirror changes are issued at random points, both inside frames and at their ends.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;
  // Frame length actually used for a programmed duty value.
  function automatic int unsigned eff_lines(int unsigned duty, int unsigned max_lines);
    return (duty == 0 || duty > max_lines) ? max_lines : duty;
  endfunction
endpackage

// File: rtl/lcdscan_line_ctr.sv
module lcdscan_line_ctr #(
  parameter int MAX_COM = 128,
  localparam int CW = $clog2(MAX_COM),
  localparam int DW = $clog2(MAX_COM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_tick,
  input  logic [DW-1:0] duty_lines,
  input  logic          com_rev,
  output logic [CW-1:0] idx_q,
  output logic [CW-1:0] idx_d,
  output logic          load,
  output logic          frame_start
);
  logic [DW-1:0] pos_q, pos_d, n_q, n_d, n_in, idx_full;
  logic          dir_q, dir_d, wrap;

  assign n_in = DW'(lcdscan_pkg::eff_lines(32'(duty_lines), MAX_COM));
  assign wrap = (pos_q == n_q - 1'b1);
  assign load = rst | line_tick;

  always_comb begin
    pos_d = pos_q;
    n_d   = n_q;
    dir_d = dir_q;
    if (rst || (line_tick && wrap)) begin
      pos_d = '0;
      n_d   = n_in;
      dir_d = com_rev;
    end else if (line_tick) begin
      pos_d = pos_q + 1'b1;
    end
    idx_full = dir_d ? (n_d - 1'b1 - pos_d) : pos_d;
    idx_d    = idx_full[CW-1:0];
  end

  always_ff @(posedge clk) begin
    pos_q       <= pos_d;
    n_q         <= n_d;
    dir_q       <= dir_d;
    idx_q       <= idx_d;
    frame_start <= !rst && line_tick && wrap;
  end

  logic [DW-1:0] idx_ext, first_line;
  assign idx_ext    = DW'(idx_q);
  assign first_line = dir_q ? (n_q - 1'b1) : '0;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_ext < n_q); // R4
  AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
    (line_tick && !dir_q && !wrap) |=> (idx_q == $past(idx_q) + 1'b1)); // R2
  AST_REV_STEP: assert property (@(posedge clk) disable iff (rst)
    (line_tick && dir_q && !wrap) |=> (idx_q == $past(idx_q) - 1'b1)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_tick |=> $stable(idx_q)); // R8
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !(line_tick && wrap) |=> ($stable(n_q) && $stable(dir_q))); // R5
  AST_FRAME_FIRST: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (idx_ext == first_line)); // R6
endmodule

// File: rtl/lcdscan_com_decode.sv
module lcdscan_com_decode #(
  parameter int MAX_COM = 128,
  localparam int CW = $clog2(MAX_COM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CW-1:0]      idx_d,
  output logic [MAX_COM-1:0] sel_q
);
  for (genvar i = 0; i < MAX_COM; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (load) sel_q[i] <= (idx_d == CW'(i));
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_q) == 1); // R7
endmodule

// File: rtl/lcdscan_slot_map.sv
module lcdscan_slot_map #(
  parameter int SLOTS = 128,
  localparam int AW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mirror,
  output logic [SLOTS*AW-1:0] addr_q
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic [AW-1:0] FWD = AW'(k);
    localparam logic [AW-1:0] REV = AW'(SLOTS - 1 - k);
    always_ff @(posedge clk) begin
      addr_q[k*AW +: AW] <= mirror ? REV : FWD;
    end
  end

  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  AST_EDGE_SLOT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_q[AW-1:0] == ($past(mirror) ? LAST : '0))); // R9

  if (SLOTS > 1) begin : g_track
    AST_MIRROR_TRACK: assert property (@(posedge clk) disable iff (rst)
      !$stable(mirror) |=> !$stable(addr_q)); // R11
  end
endmodule

// File: rtl/lcdscan_seq.sv
module lcdscan_seq #(
  parameter int MAX_COM  = 128,
  parameter int NUM_SEG  = 128,
  parameter int NUM_ICON = 5,
  localparam int CW = $clog2(MAX_COM),
  localparam int DW = $clog2(MAX_COM + 1),
  localparam int SW = $clog2(NUM_SEG),
  localparam int IW = $clog2(NUM_ICON)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   line_tick,
  input  logic [DW-1:0]          duty_lines,
  input  logic                   com_rev,
  input  logic                   seg_mirror,
  output logic [CW-1:0]          com_idx,
  output logic [MAX_COM-1:0]     com_sel,
  output logic                   frame_start,
  output logic [NUM_SEG*SW-1:0]  seg_addr,
  output logic [NUM_ICON*IW-1:0] icon_addr
);
  logic [CW-1:0] idx_d;
  logic          load;

  lcdscan_line_ctr #(.MAX_COM(MAX_COM)) u_ctr (
    .clk(clk), .rst(rst), .line_tick(line_tick), .duty_lines(duty_lines),
    .com_rev(com_rev), .idx_q(com_idx), .idx_d(idx_d), .load(load),
    .frame_start(frame_start)
  );

  lcdscan_com_decode #(.MAX_COM(MAX_COM)) u_dec (
    .clk(clk), .rst(rst), .load(load), .idx_d(idx_d), .sel_q(com_sel)
  );

  lcdscan_slot_map #(.SLOTS(NUM_SEG)) u_seg (
    .clk(clk), .rst(rst), .mirror(seg_mirror), .addr_q(seg_addr)
  );

  lcdscan_slot_map #(.SLOTS(NUM_ICON)) u_icon (
    .clk(clk), .rst(rst), .mirror(seg_mirror), .addr_q(icon_addr)
  );

  AST_SEL_MATCHES_IDX: assert property (@(posedge clk) disable iff (rst)
    com_sel[com_idx] == 1'b1); // R7
endmodule

// File: tb/lcdscan_seq_tb.sv
`timescale 1ns/1ps
module lcdscan_seq_tb;
  localparam int MAX_COM = 128, NUM_SEG = 128, NUM_ICON = 5;
  localparam int CW = 7, DW = 8, SW = 7, IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_tick = 1'b0;
  logic [DW-1:0] duty_lines = 8'd4;
  logic com_rev = 1'b0, seg_mirror = 1'b0;
  logic [CW-1:0] com_idx;
  logic [MAX_COM-1:0] com_sel;
  logic frame_start;
  logic [NUM_SEG*SW-1:0] seg_addr;
  logic [NUM_ICON*IW-1:0] icon_addr;

  always #2.5 clk = ~clk;

  lcdscan_seq u_dut (
    .clk(clk), .rst(rst), .line_tick(line_tick), .duty_lines(duty_lines),
    .com_rev(com_rev), .seg_mirror(seg_mirror), .com_idx(com_idx),
    .com_sel(com_sel), .frame_start(frame_start), .seg_addr(seg_addr),
    .icon_addr(icon_addr)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_pos, m_n, m_dir, m_fs, m_mir;

  function automatic int lines_for(int d);
    if (d < 1 || d > MAX_COM) return MAX_COM;
    return d;
  endfunction

  function automatic int exp_idx();
    return m_dir ? (m_n - 1 - m_pos) : m_pos;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model, compare just after posedge.
  task automatic step(bit r, bit t, int d, bit rev, bit mir);
    @(negedge clk);
    rst = r; line_tick = t; duty_lines = DW'(d); com_rev = rev; seg_mirror = mir;
    m_fs = 0;
    if (r) begin
      m_pos = 0; m_n = lines_for(d); m_dir = rev;
    end else if (t) begin
      if (m_pos == m_n - 1) begin
        m_pos = 0; m_n = lines_for(d); m_dir = rev; m_fs = 1;
      end else m_pos++;
    end
    m_mir = mir;
    @(posedge clk);
    #1;
    check_all();
  endtask

  task automatic check_all();
    int e = exp_idx();
    int k = $urandom_range(NUM_SEG - 1);
    int j = $urandom_range(NUM_ICON - 1);
    int es = m_mir ? (NUM_SEG - 1 - k) : k;
    int ei = m_mir ? (NUM_ICON - 1 - j) : j;
    logic [MAX_COM-1:0] exp_sel = '0;
    exp_sel[e] = 1'b1;
    chk(int'(com_idx) == e, m_dir ? "R3" : "R2", "com_idx", int'(com_idx), e);
    chk(com_sel == exp_sel, "R7", "com_sel bit count/match", $countones(com_sel), 1);
    chk(int'(frame_start) == m_fs, "R6", "frame_start", int'(frame_start), m_fs);
    chk(int'(seg_addr[k*SW +: SW]) == es, "R9", "seg slot", int'(seg_addr[k*SW +: SW]), es);
    chk(int'(icon_addr[j*IW +: IW]) == ei, "R10", "icon slot", int'(icon_addr[j*IW +: IW]), ei);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d, rv, mr;
    void'($urandom(32'h1CD5_0A11));
    // R1: reset ascending, then descending
    step(1, 0, 4, 0, 0);
    step(0, 0, 4, 0, 0);
    chk(com_idx == 0 && frame_start == 0, "R1", "reset asc idx", int'(com_idx), 0);
    step(1, 0, 6, 1, 0);
    chk(int'(com_idx) == 5, "R1", "reset desc idx", int'(com_idx), 5);
    // R3: full descending frame with wrap
    for (int i = 0; i < 7; i++) step(0, 1, 6, 1, 0);
    // R4: duty 0 and out-of-range select full length
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 127; i++) step(0, 1, 0, 0, 0);
    chk(int'(com_idx) == 127, "R4", "duty 0 reaches last line", int'(com_idx), 127);
    step(0, 1, 0, 0, 0);
    chk(com_idx == 0 && frame_start == 1, "R4", "duty 0 wraps after 128", int'(com_idx), 0);
    step(1, 0, 200, 1, 0);
    chk(int'(com_idx) == 127, "R4", "duty 200 desc start", int'(com_idx), 127);
    // R4: single-line frame restarts every tick
    step(1, 0, 1, 0, 0);
    step(0, 1, 1, 0, 0);
    chk(frame_start == 1 && com_idx == 0, "R4", "single line frame", int'(frame_start), 1);
    // R5: mid-frame changes ignored until boundary
    step(1, 0, 4, 0, 0);
    step(0, 1, 4, 0, 0);
    step(0, 1, 9, 1, 0);
    chk(int'(com_idx) == 2, "R5", "mid-frame change ignored", int'(com_idx), 2);
    step(0, 1, 9, 1, 0);
    step(0, 1, 9, 1, 0);
    chk(int'(com_idx) == 8 && frame_start == 1, "R5", "new settings at boundary", int'(com_idx), 8);
    // R8: idle clocks hold
    for (int i = 0; i < 3; i++) step(0, 0, 3, 0, 0);
    chk(int'(com_idx) == 8, "R8", "idle hold", int'(com_idx), 8);
    // R11: mirror change without a tick
    step(0, 0, 3, 0, 1);
    chk(int'(seg_addr[SW-1:0]) == 127, "R11", "mirror applied without tick", int'(seg_addr[SW-1:0]), 127);
    step(0, 0, 3, 0, 0);
    chk(int'(icon_addr[IW-1:0]) == 0, "R11", "mirror released", int'(icon_addr[IW-1:0]), 0);
    // Random phase
    d = 5; rv = 0; mr = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) < 6) begin
        case ($urandom_range(9))
          0: d = 0;
          1: d = 128;
          2: d = 130 + $urandom_range(100);
          3: d = 1;
          default: d = 1 + $urandom_range(11);
        endcase
      end
      if ($urandom_range(99) < 5) rv = ~rv & 1;
      if ($urandom_range(99) < 3) mr = ~mr & 1;
      step($urandom_range(999) == 0, $urandom_range(99) < 60, d, rv[0], mr[0]);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule